// File: doc/BRIEF.md
# Hot-Swap Bus Join Controller

This block decides when the two-wire serial segment on a plug-in card may be joined to the segment on a live backplane. It samples both data and clock lines on each side through a synchronizer. It then holds the segments apart until the backplane shows either a stop condition or a sustained quiet period. The card side must also show no line pulled low. Once both conditions hold, a single connect output closes the bidirectional buffer path. From then on the controller keeps out of the way, so clock stretching and arbitration between masters pass through untouched.

An active-high enable gates everything. While enable is low the controller is in a low-power state with the segments apart. A ready pull-down output models an open-drain status pin: it is asserted, pulling the pin low, whenever the segments are not joined. All pins are plain control and status levels. There is no streamed data and no handshake.

Top module: `hotswap_link_ctrl`

## Requirements
- R1: While reset is asserted, and on the first sampling point after it, `link_connect` is 0 and `ready_pd_oe` is 1. The controller never comes out of reset already joined.
- R2: While `enable` is 0, `link_connect` stays 0 whatever the line levels are, including a backplane that has been quiet for longer than the idle limit.
- R3: When `enable` goes to 0, `link_connect` falls at the first rising clock edge after that, whatever the state.
- R4: Bus idle means backplane SDA and SCL both sampled high for IDLE_CYCLES consecutive clocks while enabled. Any low level on either line restarts the count. With both lines already high, the join happens on the (IDLE_CYCLES+1)-th clock edge after `enable` rises. After a backplane SCL rise that ends the low period, the join happens on the (IDLE_CYCLES+3)-th edge.
- R5: A stop condition is a 0-to-1 change of synchronized backplane SDA while synchronized backplane SCL is 1. With the card quiet, the join takes effect on the third rising edge after the SDA input changes (two synchronizer stages plus one state register).
- R6: An SDA rise while backplane SCL is 0 is not a stop condition and causes no join.
- R7: No join occurs while card SDA or card SCL is sampled low. When the backplane is already idle, releasing the card line joins on the third clock edge after the release.
- R8: Once joined, the controller stays joined through any activity on either segment until `enable` falls or reset.
- R9: `ready_pd_oe` is always the inverse of `link_connect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Active-high operation enable; low selects low-power, apart |
| bp_sda_i | input | 1 | Backplane data line level |
| bp_scl_i | input | 1 | Backplane clock line level |
| cd_sda_i | input | 1 | Card data line level |
| cd_scl_i | input | 1 | Card clock line level |
| link_connect | output | 1 | 1 closes the buffer path between segments |
| ready_pd_oe | output | 1 | Pull-down enable for the open-drain ready pin; 1 while apart |

## Verification
The bench aims at the boundaries between a true stop, an SDA rise under a low clock, and a plain idle timeout, and it checks the exact clock edge on which each one joins. A design that mistook any SDA rise for a stop would join early in the low-clock case. An idle counter off by one, or one that kept counting through low levels, would join one edge early or late. Card contention is held across a backplane stop and across a full idle period. A design that ignored either card line would join while the card is still driving. Heavy toggling while joined, followed by an enable drop, shows whether bus activity can break the link and whether the disconnect takes one edge.

// File: rtl/hs_link_pkg.sv
package hs_link_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_LINKED = 2'd2
  } link_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  // Released two-wire lines idle high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '1;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hs_bus_watch.sv
module hs_bus_watch #(
  parameter int IDLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bp_sda,
  input  logic bp_scl,
  input  logic cd_sda,
  input  logic cd_scl,
  output logic stop_seen,
  output logic idle_seen,
  output logic card_quiet
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] IDLE_LIM = CW'(IDLE_CYCLES);

  logic          sda_q;
  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_q <= 1'b1;
    else        sda_q <= bp_sda;
  end

  assign stop_seen = bp_sda & ~sda_q & bp_scl;

  // Counts consecutive high-high samples, saturating at the limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          quiet_cnt <= '0;
    else if (!run || !(bp_sda && bp_scl)) quiet_cnt <= '0;
    else if (quiet_cnt != IDLE_LIM)      quiet_cnt <= quiet_cnt + 1'b1;
  end

  assign idle_seen  = (quiet_cnt == IDLE_LIM);
  assign card_quiet = cd_sda & cd_scl;
endmodule

// File: rtl/hs_link_fsm.sv
module hs_link_fsm
  import hs_link_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic stop_seen,
  input  logic idle_seen,
  input  logic card_quiet,
  output logic link_connect
);
  link_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    if (!enable) begin
      state_nx = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:    state_nx = ST_WAIT;
        ST_WAIT:   if ((stop_seen || idle_seen) && card_quiet) state_nx = ST_LINKED;
        ST_LINKED: state_nx = ST_LINKED;
        default:   state_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= state_nx;
  end

  assign link_connect = (state == ST_LINKED);
endmodule

// File: rtl/hotswap_link_ctrl.sv
module hotswap_link_ctrl #(
  parameter int IDLE_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  input  logic cd_sda_i,
  input  logic cd_scl_i,
  output logic link_connect,
  output logic ready_pd_oe
);
  localparam int NLINES = 4;

  logic [NLINES-1:0] raw_lines, sync_lines;
  logic stop_seen, idle_seen, card_quiet;

  assign raw_lines = {cd_scl_i, cd_sda_i, bp_scl_i, bp_sda_i};

  hs_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
  );

  hs_bus_watch #(.IDLE_CYCLES(IDLE_CYCLES)) u_watch (
    .clk(clk), .rst_n(rst_n), .run(enable),
    .bp_sda(sync_lines[0]), .bp_scl(sync_lines[1]),
    .cd_sda(sync_lines[2]), .cd_scl(sync_lines[3]),
    .stop_seen(stop_seen), .idle_seen(idle_seen), .card_quiet(card_quiet)
  );

  hs_link_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .stop_seen(stop_seen), .idle_seen(idle_seen), .card_quiet(card_quiet),
    .link_connect(link_connect)
  );

  assign ready_pd_oe = ~link_connect;
endmodule

// File: rtl/hs_link_checker.sv
module hs_link_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic link_connect,
  input logic ready_pd_oe,
  input logic stop_seen,
  input logic idle_seen,
  input logic card_quiet
);
  a_r1_reset_apart: assert property (@(posedge clk) $rose(rst_n) |-> !link_connect);

  a_r2_off_no_join: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_connect) |-> $past(enable));

  a_r3_fast_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !link_connect);

  a_r5_join_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_connect) |-> $past(stop_seen || idle_seen));

  a_r7_card_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_connect) |-> $past(card_quiet));

  a_r8_hold_link: assert property (@(posedge clk) disable iff (!rst_n)
    (link_connect && enable) |=> link_connect);

  a_r9_ready_pin: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pd_oe == !link_connect);
endmodule

bind hotswap_link_ctrl hs_link_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .link_connect(link_connect), .ready_pd_oe(ready_pd_oe),
  .stop_seen(stop_seen), .idle_seen(idle_seen), .card_quiet(card_quiet)
);

// File: tb/test_hotswap_link_ctrl.sv
`timescale 1ns/1ps
module test_hotswap_link_ctrl;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic bp_sda = 1'b1, bp_scl = 1'b1, cd_sda = 1'b1, cd_scl = 1'b1;
  logic link_connect, ready_pd_oe;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { int at; bit conn; string tag; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hotswap_link_ctrl #(.IDLE_CYCLES(N)) i_hotswap_link_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .bp_sda_i(bp_sda), .bp_scl_i(bp_scl), .cd_sda_i(cd_sda), .cd_scl_i(cd_scl),
    .link_connect(link_connect), .ready_pd_oe(ready_pd_oe)
  );

  // Driver side: expected items, kept in cycle order.
  task automatic push(int at, bit v, string tag);
    exp_t e;
    int pos;
    e.at = at; e.conn = v; e.tag = tag;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].at > at) begin pos = i; break; end
    end
    sb.insert(pos, e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops due items and compares at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (link_connect !== e.conn) begin
        errors++;
        $display("FAIL %s cycle %0d: link_connect=%b expected %b", e.tag, cyc, link_connect, e.conn);
      end
      checks++;
      if (ready_pd_oe !== ~e.conn) begin
        errors++;
        $display("FAIL R9 (%s) cycle %0d: ready_pd_oe=%b expected %b", e.tag, cyc, ready_pd_oe, ~e.conn);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    tick(2);
    push(cyc + 1, 1'b0, "R1");
    push(cyc + 2, 1'b0, "R1");
    tick(3);
    rst_n = 1'b1;
    push(cyc + 1, 1'b0, "R1");
    c = cyc;
    push(c + 30, 1'b0, "R2");
    tick(30);

    // R4: idle join timed from enable rise, lines already high
    c = cyc; enable = 1'b1;
    push(c + N, 1'b0, "R4");
    push(c + N + 1, 1'b1, "R4");
    tick(N + 5);

    // R8: traffic on both segments while joined
    c = cyc;
    push(c + 10, 1'b1, "R8");
    push(c + 22, 1'b1, "R8");
    for (int i = 0; i < 20; i++) begin
      bp_sda = i[0]; bp_scl = i[1]; cd_sda = i[2]; cd_scl = i[3];
      tick(1);
    end
    bp_sda = 1'b1; bp_scl = 1'b1; cd_sda = 1'b1; cd_scl = 1'b1;
    tick(4);

    // R3: enable drop from the joined state
    c = cyc; enable = 1'b0;
    push(c + 1, 1'b0, "R3");
    tick(5);

    // R5: stop condition joins well before the idle limit
    bp_sda = 1'b0; tick(5);
    c = cyc; enable = 1'b1;
    push(c + 20, 1'b0, "R5");
    tick(20);
    c = cyc; bp_sda = 1'b1;
    push(c + 2, 1'b0, "R5");
    push(c + 3, 1'b1, "R5");
    tick(6);
    enable = 1'b0; tick(3);

    // R6: SDA rise under low SCL is not a stop; then idle from SCL rise
    bp_sda = 1'b0; bp_scl = 1'b0; tick(4);
    enable = 1'b1; tick(10);
    c = cyc; bp_sda = 1'b1;
    push(c + 6, 1'b0, "R6");
    tick(6);
    c = cyc; bp_scl = 1'b1;
    push(c + 3, 1'b0, "R6");
    push(c + 2 + N, 1'b0, "R4");
    push(c + 3 + N, 1'b1, "R4");
    tick(N + 6);
    enable = 1'b0; tick(3);

    // R7: card SDA held low through a full idle period
    cd_sda = 1'b0; enable = 1'b1;
    c = cyc;
    push(c + N + 10, 1'b0, "R7");
    tick(N + 10);
    c = cyc; cd_sda = 1'b1;
    push(c + 2, 1'b0, "R7");
    push(c + 3, 1'b1, "R7");
    tick(5);
    enable = 1'b0; tick(3);

    // R7: card SCL held low across a backplane stop and idle
    cd_scl = 1'b0; bp_sda = 1'b0; enable = 1'b1; tick(4);
    c = cyc; bp_sda = 1'b1;
    push(c + 4, 1'b0, "R7");
    push(c + N + 6, 1'b0, "R7");
    tick(N + 6);
    c = cyc; cd_scl = 1'b1;
    push(c + 2, 1'b0, "R7");
    push(c + 3, 1'b1, "R7");
    tick(5);

    while (sb.size() > 0) tick(1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule